// File: doc/BRIEF.md
# Calendar Clock Register File

This block is a calendar clock whose registers are reached through two ports that share one byte bus. A write with the index-select line high stores a register number. Later accesses with that line low then write or read the named register. The clock keeps seconds, minutes, hours, day of month, month and a two-digit year. A prescaler advances these fields once per second, and the prescaler period is set as a count of system clocks.

Two bits let software set the time without a carry landing halfway through the update. A freeze bit in the control register stops the fields from advancing. A divider-hold code in the frequency register parks the prescaler at its half-period point. Software first clears the freeze bit and then releases the hold. The first increment then arrives exactly half a period after the release.

A busy flag, readable in bit 7 of the frequency register, is high for a fixed number of clocks just before each increment. When it drops, the fields already hold the second that has just begun. A mode bit selects how the fields are stored and counted: packed BCD or plain binary.

Top module: `cal_clock`

## Requirements
- R1: A bus write with `bus_sel_idx`=1 loads the index. A following write with `bus_sel_idx`=0 stores the byte in the indexed register, and `bus_rdata` with `bus_sel_idx`=0 shows that register. The register numbers are: 0 seconds, 2 minutes, 4 hours, 7 day, 8 month, 9 year, 10 frequency, 11 control.
- R2: After reset the fields read seconds 0, minutes 0, hours 0, day 1, month 1, year 0. Control reads 0x00, and frequency reads 0x60 (divider held).
- R3: While control bit 7 (freeze) is 1, no time field changes except by a bus write, however many prescaler periods pass.
- R4: While frequency bits 6:5 are both 1, the prescaler is held. No field advances and the busy flag stays 0.
- R5: The first increment lands exactly TICK_CLKS/2 clock edges after the edge that stores a frequency value without the hold code. Later increments follow every TICK_CLKS edges.
- R6: Frequency bit 7 (busy) is 1 for exactly UIP_CLKS cycles just before each increment. From the cycle in which it reads 0 again, the fields show the new second.
- R7: With control bit 2 = 0, the fields are counted in packed BCD, for example 0x09 goes to 0x10 and 0x59 goes to 0x00.
- R8: With control bit 2 = 1, the fields are counted in binary, for example 9 goes to 10 and 59 goes to 0.
- R9: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one step into the next field.
- R10: The day wraps to 1 after the month length: 28 for month 2, 30 for months 4, 6, 9 and 11, and 31 for the others. Month wraps from 12 to 1, and the year wraps from 99 to 0.
- R11: Writes to frequency bit 7 are ignored. Register numbers outside the list in R1 ignore writes and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for the port chosen by `bus_sel_idx` |
| bus_sel_idx | input | 1 | 1 selects the index port, 0 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Index (when `bus_sel_idx`=1) or the indexed register |

## Verification
The bench builds the clock with TICK_CLKS=16 and UIP_CLKS=3. A half period is therefore eight clocks and the busy window three. At that scale, every release-to-increment gap and every busy window can be checked cycle by cycle. With one short program-release-read cycle per case, the bench sweeps every second, minute and hour value, every month end and every year in both encodings. The scale also leaves room to wait several periods under freeze or divider hold.

// File: rtl/cal_pkg.sv
// Shared constants and helpers for the calendar clock.
// Assumes byte-wide fields; BCD helpers take values 0..99.
package cal_pkg;
    localparam int NFLD = 6;
    localparam logic [7:0] REG_FRQ = 8'd10;
    localparam logic [7:0] REG_CTL = 8'd11;

    // Register number for time field i (0 = seconds ... 5 = year).
    function automatic logic [7:0] fld_addr(input int i);
        case (i)
            0:       return 8'd0;
            1:       return 8'd2;
            2:       return 8'd4;
            3:       return 8'd7;
            4:       return 8'd8;
            default: return 8'd9;
        endcase
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    // Days in month m (no leap-year rule).
    function automatic logic [7:0] month_days(input logic [7:0] m);
        case (m)
            8'd2:                      return 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
// Down-counting one-second prescaler.
// While held it parks at half a period, so the first tick after release
// comes TICK_CLKS/2 edges later. The busy flag covers the last UIP_CLKS
// cycles before each tick. Assumes UIP_CLKS < TICK_CLKS/2.
module cal_prescaler #(
    parameter int TICK_CLKS = 32768,
    parameter int UIP_CLKS  = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick,
    output logic uip
);
    localparam int CW = $clog2(TICK_CLKS + 1);

    logic [CW-1:0] cnt;

    // Count down to 1, reload a full period; park at half while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            cnt <= CW'(TICK_CLKS / 2);
        else if (cnt == CW'(1))
            cnt <= CW'(TICK_CLKS);
        else
            cnt <= cnt - CW'(1);
    end

    // Tick and busy window decode.
    always_comb begin
        tick = !hold && (cnt == CW'(1));
        uip  = !hold && (cnt <= CW'(UIP_CLKS));
    end
endmodule

// File: rtl/cal_timekeeper.sv
// Six calendar fields with a ripple of carries through them.
// Fields are counted in BCD or binary per bin_mode.
// A bus write to a field wins over a step in the same cycle.
module cal_timekeeper
    import cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                bin_mode,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [7:0]          wr_data,
    output logic [8*NFLD-1:0]   fields
);
    logic [7:0]    bv  [NFLD];
    logic [7:0]    nxt [NFLD];
    logic [NFLD:0] cin;

    // Decode, increment with wrap, carry, re-encode for every field.
    always_comb begin
        logic [7:0] lim;
        logic [7:0] lo;
        logic [7:0] nb;
        logic       wrap;
        cin[0] = 1'b1;
        for (int i = 0; i < NFLD; i++) begin
            bv[i] = bin_mode ? fields[8*i +: 8] : bcd_to_bin(fields[8*i +: 8]);
        end
        for (int i = 0; i < NFLD; i++) begin
            case (i)
                0, 1:    lim = 8'd59;
                2:       lim = 8'd23;
                3:       lim = month_days(bv[4]);
                4:       lim = 8'd12;
                default: lim = 8'd99;
            endcase
            lo       = (i == 3 || i == 4) ? 8'd1 : 8'd0;
            wrap     = bv[i] >= lim;
            nb       = wrap ? lo : bv[i] + 8'd1;
            cin[i+1] = cin[i] && wrap;
            nxt[i]   = bin_mode ? nb : bin_to_bcd(nb);
        end
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        localparam logic [7:0] RST = (g == 3 || g == 4) ? 8'd1 : 8'd0;
        logic [7:0] r;
        // Field register: reset, bus write, or carry-driven advance.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= RST;
            else if (wr_en && wr_addr == fld_addr(g))
                r <= wr_data;
            else if (step && cin[g])
                r <= nxt[g];
        end
        assign fields[8*g +: 8] = r;
    end
endmodule

// File: rtl/cal_clock.sv
// Calendar clock top: index/data port, control and frequency registers,
// prescaler and time fields. Reads have no side effects.
module cal_clock
    import cal_pkg::*;
#(
    parameter int TICK_CLKS = 32768,
    parameter int UIP_CLKS  = 72
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       bus_sel_idx,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    logic [7:0]          idx_q;
    logic [7:0]          ctl_q;
    logic [6:0]          frq_q;
    logic                data_wr;
    logic                time_wr;
    logic                div_held;
    logic                tick_w;
    logic                uip_w;
    logic                step;
    logic [8*NFLD-1:0]   fields;

    assign data_wr  = bus_we && !bus_sel_idx;
    assign div_held = (frq_q[6:5] == 2'b11);
    assign step     = tick_w && !ctl_q[7];

    // Flag bus writes that land on a time field.
    always_comb begin
        time_wr = 1'b0;
        for (int i = 0; i < NFLD; i++)
            if (data_wr && idx_q == fld_addr(i)) time_wr = 1'b1;
    end

    // Index, control and frequency registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'd0;
            ctl_q <= 8'h00;
            frq_q <= 7'h60;
        end else if (bus_we) begin
            if (bus_sel_idx)              idx_q <= bus_wdata;
            else if (idx_q == REG_CTL)    ctl_q <= bus_wdata;
            else if (idx_q == REG_FRQ)    frq_q <= bus_wdata[6:0];
        end
    end

    cal_prescaler #(.TICK_CLKS(TICK_CLKS), .UIP_CLKS(UIP_CLKS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (div_held),
        .tick  (tick_w),
        .uip   (uip_w)
    );

    cal_timekeeper u_tk (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .bin_mode (ctl_q[2]),
        .wr_en    (data_wr),
        .wr_addr  (idx_q),
        .wr_data  (bus_wdata),
        .fields   (fields)
    );

    // Read mux: index port or the register named by the index.
    always_comb begin
        if (bus_sel_idx)
            bus_rdata = idx_q;
        else begin
            case (idx_q)
                8'd0:    bus_rdata = fields[7:0];
                8'd2:    bus_rdata = fields[15:8];
                8'd4:    bus_rdata = fields[23:16];
                8'd7:    bus_rdata = fields[31:24];
                8'd8:    bus_rdata = fields[39:32];
                8'd9:    bus_rdata = fields[47:40];
                REG_FRQ: bus_rdata = {uip_w, frq_q};
                REG_CTL: bus_rdata = ctl_q;
                default: bus_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cal_clock_chk.sv
// Temporal checks on the calendar clock, attached by bind.
module cal_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       held,
    input logic       uip,
    input logic       tick,
    input logic       step,
    input logic       set,
    input logic       time_wr,
    input logic [7:0] sec
);
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (!uip && !tick)); // R4

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !time_wr) |=> $stable(sec)); // R3

    AST_FREEZE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !time_wr) |=> $stable(sec)); // R3

    AST_UIP_FALL_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !held && !$past(set) && !$past(time_wr))
            |-> (sec != $past(sec))); // R6
endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .held    (div_held),
    .uip     (uip_w),
    .tick    (tick_w),
    .step    (step),
    .set     (ctl_q[7]),
    .time_wr (time_wr),
    .sec     (fields[7:0])
);

// File: tb/sim_cal_clock.sv
// Sweeping bench for cal_clock at a small time scale.
module sim_cal_clock;
    localparam int TICK = 16;
    localparam int UIP  = 3;
    localparam int HALF = TICK / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_sel_idx = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cal_clock #(.TICK_CLKS(TICK), .UIP_CLKS(UIP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel_idx(bus_sel_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel_idx = sel; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        wr(1'b1, a);
        wr(1'b0, d);
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] v);
        wr(1'b1, a);
        bus_sel_idx = 1'b0;
        #1 v = bus_rdata;
    endtask

    function automatic logic [7:0] enc(input int v, input bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // Program a time, release, check busy timing and the advanced fields.
    task automatic run_case(input bit bin, input int s, input int mi, input int h,
                            input int d, input int mo, input int y, input string tag);
        int e[6];
        int st[6];
        bit c;
        int bad;
        logic [7:0] v;
        logic [7:0] adr[6] = '{8'd0, 8'd2, 8'd4, 8'd7, 8'd8, 8'd9};
        st = '{s, mi, h, d, mo, y};
        c = 1;
        e[0] = (s >= 59) ? 0 : s + 1;          c = (s >= 59);
        e[1] = c ? ((mi >= 59) ? 0 : mi + 1) : mi;  c = c && (mi >= 59);
        e[2] = c ? ((h >= 23) ? 0 : h + 1) : h;     c = c && (h >= 23);
        e[3] = c ? ((d >= mlen(mo)) ? 1 : d + 1) : d; c = c && (d >= mlen(mo));
        e[4] = c ? ((mo >= 12) ? 1 : mo + 1) : mo;  c = c && (mo >= 12);
        e[5] = c ? ((y >= 99) ? 0 : y + 1) : y;
        wreg(8'd10, 8'h60);
        wreg(8'd11, 8'h80 | (bin ? 8'h04 : 8'h00));
        for (int i = 0; i < 6; i++) wreg(adr[i], enc(st[i], bin));
        wreg(8'd11, bin ? 8'h04 : 8'h00);
        wreg(8'd10, 8'h20);
        bus_sel_idx = 1'b0;
        bad = 0;
        for (int k = 1; k <= HALF; k++) begin
            @(negedge clk);
            #1 if (bus_rdata[7] != ((k >= HALF - UIP) && (k < HALF))) bad++;
        end
        chk(bad == 0, "R5 R6 busy window after release", bad, 0);
        for (int i = 0; i < 6; i++) begin
            rreg(adr[i], v);
            chk(v == enc(e[i], bin), tag, v, enc(e[i], bin));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rreg(8'd10, v); chk(v == 8'h60, "R2 frequency reset", v, 8'h60);
        rreg(8'd11, v); chk(v == 8'h00, "R2 control reset", v, 8'h00);
        rreg(8'd0, v);  chk(v == 8'h00, "R2 seconds reset", v, 8'h00);
        rreg(8'd7, v);  chk(v == 8'h01, "R2 day reset", v, 8'h01);
        rreg(8'd8, v);  chk(v == 8'h01, "R2 month reset", v, 8'h01);

        // R1 indirect write and readback
        wreg(8'd2, 8'h37); rreg(8'd2, v); chk(v == 8'h37, "R1 minutes readback", v, 8'h37);
        wreg(8'd11, 8'h7B); rreg(8'd11, v); chk(v == 8'h7B, "R1 control readback", v, 8'h7B);
        wreg(8'd11, 8'h00);
        wr(1'b1, 8'd9); #1 chk(bus_rdata == 8'd9, "R1 index readback", bus_rdata, 9);

        // R11 read-only busy bit and unused numbers
        wreg(8'd10, 8'hE0); rreg(8'd10, v); chk(v == 8'h60, "R11 busy bit not writable", v, 8'h60);
        wreg(8'd0, 8'h12); wreg(8'd5, 8'h55);
        rreg(8'd5, v); chk(v == 8'h00, "R11 unused reads zero", v, 0);
        rreg(8'd0, v); chk(v == 8'h12, "R11 unused write leaves seconds", v, 8'h12);

        // R4 divider held: no busy, no advance
        wr(1'b1, 8'd10); bus_sel_idx = 1'b0; cnt = 0;
        for (int k = 0; k < 3 * TICK; k++) begin @(negedge clk); #1 if (bus_rdata[7]) cnt++; end
        chk(cnt == 0, "R4 busy stays low while held", cnt, 0);
        rreg(8'd0, v); chk(v == 8'h12, "R4 seconds hold while held", v, 8'h12);

        // R3 freeze with divider running
        wreg(8'd11, 8'h80); wreg(8'd10, 8'h20);
        repeat (3 * TICK) @(negedge clk);
        rreg(8'd0, v); chk(v == 8'h12, "R3 seconds frozen", v, 8'h12);
        wreg(8'd11, 8'h00); wreg(8'd10, 8'h60);

        // R5 period: falls at HALF, HALF+TICK, HALF+2*TICK after release
        wreg(8'd0, 8'h00); wreg(8'd10, 8'h20); bus_sel_idx = 1'b0;
        prev = 1'b0; cnt = 0;
        for (int k = 1; k <= HALF + 2 * TICK + 1; k++) begin
            @(negedge clk);
            #1 if (prev && !bus_rdata[7]) begin
                chk(k == HALF + cnt * TICK, "R5 update spacing", k, HALF + cnt * TICK);
                cnt++;
            end
            prev = bus_rdata[7];
        end
        chk(cnt == 3, "R5 update count", cnt, 3);
        rreg(8'd0, v); chk(v == 8'h03, "R6 seconds after three updates", v, 8'h03);

        // Sweeps in both encodings
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 60; s++) run_case(b[0], s, 5, 7, 3, 6, 21, b ? "R8 seconds" : "R7 seconds");
            for (int m = 0; m < 60; m++) run_case(b[0], 59, m, 10, 9, 3, 42, "R9 minute carry");
            for (int h = 0; h < 24; h++) run_case(b[0], 59, 59, h, 14, 8, 7, "R9 hour carry");
            for (int mo = 1; mo <= 12; mo++) run_case(b[0], 59, 59, 23, mlen(mo), mo, 50, "R10 month end");
            for (int y = 0; y < 100; y++) run_case(b[0], 59, 59, 23, 31, 12, y, "R10 year wrap");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule